// File: doc/BRIEF.md
# Interleaved DRAM Node Address Router

This block decides which memory node owns a 40-bit physical request address. It holds eight programmable address windows. Each window has a lower bound and an upper bound on address bits 39:24, so every window is aligned to 16 MB. A window also carries separate enables for reads and writes, a destination node number, and an optional interleave rule. The interleave rule lets two, four or eight windows share one address span, with the owner chosen by address bits 14:12.

Configuration enters through a simple write-only CSR port. Requests present an address and a read/write flag. One cycle later the block returns a registered response: a hit flag, the destination node and the number of the window that matched. When more than one window matches, the lowest-numbered window wins.

Top module: `dram_node_router`

## Requirements
- R1: A window matches only when its lower bound <= req_addr[39:24] <= its upper bound. Both ends are inclusive.
- R2: A read (req_write=0) can match a window only when the window's read-enable bit is set (lower-bound word bit 0). A write (req_write=1) can match only when the window's write-enable bit is set (lower-bound word bit 1).
- R3: On a hit, rsp_node equals the node field of the matching window (upper-bound word bits 2:0).
- R4: The interleave code sits in lower-bound word bits 10:8. Code 000 ignores A[14:12]. Code 001 compares A[12]. Code 011 compares A[12] and A[14]. Code 111 compares A[14:12]. In each case the comparison is against the select value in upper-bound word bits 10:8, and bits that are not compared are ignored.
- R5: A window whose interleave code is 010, 100, 101 or 110 never matches.
- R6: When several windows match, the lowest-numbered one wins, and rsp_idx reports its number.
- R7: On a miss, rsp_hit is 0, rsp_node is 0 and rsp_idx is 0.
- R8: rsp_valid is high in the cycle after each cycle with req_valid high, and low otherwise. While req_valid is low, rsp_hit, rsp_node and rsp_idx keep their values.
- R9: After reset, rsp_valid is 0 and every window is disabled, so any request misses.
- R10: A CSR write selects the lower-bound word when csr_addr[0]=0 and the upper-bound word when csr_addr[0]=1. csr_addr[3:1] selects the window. Each bound sits in data bits 31:16. The write applies to requests presented in any later cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_we | input | 1 | Configuration write strobe |
| csr_addr | input | 4 | Window number (bits 3:1) and word select (bit 0) |
| csr_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 40 | Physical request address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_hit | output | 1 | Some window claimed the address |
| rsp_node | output | 3 | Destination node, 0 on a miss |
| rsp_idx | output | 3 | Number of the winning window, 0 on a miss |

## Verification
The bench sweeps bound values on both sides of every window edge. At each one it tries all eight A[14:12] patterns, for both reads and writes, and compares the result with a model built from the requirements. An off-by-one bound compare would gain or lose a window at its edge. A wrong mask for the 4-node code (for example, comparing A[13] in place of A[14]) would split a window shared by interleaving in the wrong place. A decoder that accepts a reserved code would claim addresses for a window that must stay silent. The overlapping windows and the write-only and read-only windows show whether the priority order or the enable checks are inverted. A late reconfiguration that clears a window's enables checks that the next window in line then takes over.

// File: rtl/dnr_pkg.sv
package dnr_pkg;

    localparam int RANGE_W     = 16;
    localparam int NODE_W      = 3;
    localparam int ILV_W       = 3;
    localparam int CSR_DATA_W  = 32;

    // field positions inside the configuration words
    localparam int F_REN       = 0;
    localparam int F_WEN       = 1;
    localparam int F_NODE_LSB  = 0;
    localparam int F_ILV_LSB   = 8;
    localparam int F_RANGE_LSB = 16;

    typedef struct packed {
        logic [RANGE_W-1:0] lo;
        logic [RANGE_W-1:0] hi;
        logic [ILV_W-1:0]   ilv_code;
        logic [ILV_W-1:0]   ilv_sel;
        logic [NODE_W-1:0]  node;
        logic               ren;
        logic               wen;
    } window_cfg_t;

    typedef struct packed {
        logic              legal;
        logic [ILV_W-1:0]  mask;
    } ilv_rule_t;

    // mask bit 0 guards A[12], bit 1 A[13], bit 2 A[14]
    function automatic ilv_rule_t ilv_decode(input logic [ILV_W-1:0] code);
        ilv_rule_t r;
        unique case (code)
            3'b000:  r = '{legal: 1'b1, mask: 3'b000};
            3'b001:  r = '{legal: 1'b1, mask: 3'b001};
            3'b011:  r = '{legal: 1'b1, mask: 3'b101};
            3'b111:  r = '{legal: 1'b1, mask: 3'b111};
            default: r = '{legal: 1'b0, mask: 3'b000};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dnr_cfg_regs.sv
module dnr_cfg_regs
    import dnr_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      csr_we,
    input  logic [IDX_W:0]            csr_addr,
    input  logic [CSR_DATA_W-1:0]     csr_wdata,
    output window_cfg_t [NWIN-1:0]    cfg_o
);

    window_cfg_t [NWIN-1:0] cfg_d, cfg_q;
    logic [IDX_W-1:0]       sel_win;

    assign sel_win = csr_addr[IDX_W:1];

    always_comb begin
        cfg_d = cfg_q;
        if (csr_we && (int'(sel_win) < NWIN)) begin
            if (csr_addr[0]) begin
                cfg_d[sel_win].hi      = csr_wdata[F_RANGE_LSB +: RANGE_W];
                cfg_d[sel_win].ilv_sel = csr_wdata[F_ILV_LSB +: ILV_W];
                cfg_d[sel_win].node    = csr_wdata[F_NODE_LSB +: NODE_W];
            end else begin
                cfg_d[sel_win].lo       = csr_wdata[F_RANGE_LSB +: RANGE_W];
                cfg_d[sel_win].ilv_code = csr_wdata[F_ILV_LSB +: ILV_W];
                cfg_d[sel_win].ren      = csr_wdata[F_REN];
                cfg_d[sel_win].wen      = csr_wdata[F_WEN];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/dnr_window_match.sv
module dnr_window_match
    import dnr_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int RANGE_LSB = 24,
    parameter int ILV_LSB   = 12
) (
    input  window_cfg_t        cfg,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               is_write,
    output logic               match
);

    logic [RANGE_W-1:0] a_hi;
    logic [ILV_W-1:0]   a_ilv;
    ilv_rule_t          rule;
    logic               in_range, allowed, ilv_ok;

    always_comb begin
        a_hi     = addr[RANGE_LSB +: RANGE_W];
        a_ilv    = addr[ILV_LSB +: ILV_W];
        rule     = ilv_decode(cfg.ilv_code);
        in_range = (a_hi >= cfg.lo) && (a_hi <= cfg.hi);
        allowed  = is_write ? cfg.wen : cfg.ren;
        ilv_ok   = rule.legal && (((a_ilv ^ cfg.ilv_sel) & rule.mask) == '0);
        match    = in_range && allowed && ilv_ok;
    end

endmodule

// File: rtl/dnr_prio_pick.sv
module dnr_prio_pick #(
    parameter int NWIN  = 8,
    parameter int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic [NWIN-1:0]  match,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dram_node_router.sv
module dram_node_router
    import dnr_pkg::*;
#(
    parameter int NWIN      = 8,
    parameter int ADDR_W    = 40,
    parameter int RANGE_LSB = 24,
    parameter int ILV_LSB   = 12,
    localparam int IDX_W    = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   csr_we,
    input  logic [IDX_W:0]         csr_addr,
    input  logic [CSR_DATA_W-1:0]  csr_wdata,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic                   req_write,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [NODE_W-1:0]      rsp_node,
    output logic [IDX_W-1:0]       rsp_idx
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [NODE_W-1:0] node;
        logic [IDX_W-1:0]  idx;
    } rsp_t;

    window_cfg_t [NWIN-1:0] cfg;
    logic [NWIN-1:0]        win_match;
    logic                   any_hit;
    logic [IDX_W-1:0]       win_idx;
    rsp_t                   rsp_d, rsp_q;

    dnr_cfg_regs #(.NWIN(NWIN), .IDX_W(IDX_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .cfg_o     (cfg)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        dnr_window_match #(
            .ADDR_W    (ADDR_W),
            .RANGE_LSB (RANGE_LSB),
            .ILV_LSB   (ILV_LSB)
        ) i_match (
            .cfg      (cfg[g]),
            .addr     (req_addr),
            .is_write (req_write),
            .match    (win_match[g])
        );
    end

    dnr_prio_pick #(.NWIN(NWIN), .IDX_W(IDX_W)) i_pick (
        .match (win_match),
        .found (any_hit),
        .idx   (win_idx)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.hit  = any_hit;
            rsp_d.idx  = any_hit ? win_idx : '0;
            rsp_d.node = any_hit ? cfg[win_idx].node : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_node  = rsp_q.node;
    assign rsp_idx   = rsp_q.idx;

endmodule

// File: rtl/dnr_checker.sv
module dnr_checker
    import dnr_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int IDX_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  csr_we,
    input logic [IDX_W:0]        csr_addr,
    input logic [CSR_DATA_W-1:0] csr_wdata,
    input logic                  req_valid,
    input logic                  req_write,
    input logic                  rsp_valid,
    input logic                  rsp_hit,
    input logic [NODE_W-1:0]     rsp_node,
    input logic [IDX_W-1:0]      rsp_idx
);

    // shadow of lower-bound words seen on the CSR port
    logic [NWIN-1:0] sh_ren, sh_wen, sh_bad;
    logic [NWIN-1:0] at_ren, at_wen, at_bad;
    logic            at_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_ren <= '0; sh_wen <= '0; sh_bad <= '0;
            at_ren <= '0; at_wen <= '0; at_bad <= '0;
            at_write <= 1'b0;
        end else begin
            at_ren   <= sh_ren;
            at_wen   <= sh_wen;
            at_bad   <= sh_bad;
            at_write <= req_write;
            if (csr_we && !csr_addr[0] && (int'(csr_addr[IDX_W:1]) < NWIN)) begin
                sh_ren[csr_addr[IDX_W:1]] <= csr_wdata[F_REN];
                sh_wen[csr_addr[IDX_W:1]] <= csr_wdata[F_WEN];
                sh_bad[csr_addr[IDX_W:1]] <= !ilv_decode(csr_wdata[F_ILV_LSB +: ILV_W]).legal;
            end
        end
    end

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_hit) && $stable(rsp_node) && $stable(rsp_idx)));
    a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_node == '0 && rsp_idx == '0));
    a_r2_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (at_write ? at_wen[rsp_idx] : at_ren[rsp_idx]));
    a_r5_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !at_bad[rsp_idx]);

endmodule

bind dram_node_router dnr_checker #(.NWIN(NWIN), .IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_dram_node_router.sv
module test_dram_node_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [3:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid, rsp_hit;
    logic [2:0]  rsp_node, rsp_idx;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_lo [8];
    logic [31:0] m_hi [8];

    always #2.5 clk = ~clk;

    dram_node_router i_dram_node_router (.*);

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int win, input bit upper, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = {win[2:0], upper}; csr_wdata = d;
        if (upper) m_hi[win] = d; else m_lo[win] = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    // expected response {hit, node, idx}
    function automatic logic [6:0] model(input logic [39:0] a, input bit w);
        for (int i = 0; i < 8; i++) begin
            logic [2:0] code, mask, sel;
            bit legal, en;
            code = m_lo[i][10:8];
            sel  = m_hi[i][10:8];
            legal = 1'b1;
            case (code)
                3'b000: mask = 3'b000;
                3'b001: mask = 3'b001;
                3'b011: mask = 3'b101;
                3'b111: mask = 3'b111;
                default: begin mask = 3'b000; legal = 1'b0; end
            endcase
            en = w ? m_lo[i][1] : m_lo[i][0];
            if (legal && en && a[39:24] >= m_lo[i][31:16] && a[39:24] <= m_hi[i][31:16]
                && ((a[14:12] ^ sel) & mask) == 3'b000)
                return {1'b1, m_hi[i][2:0], i[2:0]};
        end
        return 7'b0;
    endfunction

    task automatic probe(input string req, input logic [39:0] a, input bit w);
        logic [6:0] e;
        e = model(a, w);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, {31'b0, rsp_valid}, 32'd1);
        check(req, {25'b0, rsp_hit, rsp_node, rsp_idx}, {25'b0, e});
    endtask

    localparam int NPTS = 21;
    logic [15:0] pts [NPTS] = '{16'h0000, 16'h000F, 16'h0010, 16'h0017, 16'h0018,
        16'h001F, 16'h0020, 16'h0030, 16'h0031, 16'h00FF, 16'h0100, 16'h01FF,
        16'h0200, 16'h02FF, 16'h0300, 16'h03FF, 16'h0400, 16'h04FF, 16'hFEFF,
        16'hFF00, 16'hFFFF};

    initial begin
        for (int i = 0; i < 8; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        repeat (3) @(negedge clk);
        check("R9 reset valid", {31'b0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        // R9: nothing enabled after reset
        probe("R9 all disabled rd", 40'h00_1000_0000, 1'b0);
        probe("R9 all disabled wr", 40'hFF_FFFF_F000, 1'b1);

        // R10: upper word first, then lower word carrying enables
        wr(0, 1, 32'h001F_0005); wr(0, 0, 32'h0010_0003);
        wr(1, 1, 32'h0030_0002); wr(1, 0, 32'h0018_0001);
        wr(2, 1, 32'h01FF_0103); wr(2, 0, 32'h0100_0103);
        wr(3, 1, 32'h01FF_0004); wr(3, 0, 32'h0100_0103);
        wr(4, 1, 32'h02FF_0606); wr(4, 0, 32'h0200_0303);
        wr(5, 1, 32'h03FF_0507); wr(5, 0, 32'h0300_0702);
        wr(6, 1, 32'h04FF_0001); wr(6, 0, 32'h0400_0203);
        wr(7, 1, 32'hFFFF_0000); wr(7, 0, 32'hFF00_0003);

        // R1 R2 R3 R4 R5 R6 R7: sweep bounds x A[14:12] x direction
        foreach (pts[p]) begin
            for (int s = 0; s < 8; s++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [39:0] a;
                    a = {pts[p], 9'h0, s[2:0], 12'hABC};
                    probe("R1-sweep R2 R3 R4 R5 R6 R7", a, w[0]);
                end
            end
        end

        // R8: idle cycles keep the last response and drop valid
        probe("R8 setup", 40'h00_1000_0000, 1'b0);
        @(negedge clk);
        check("R8 valid low when idle", {31'b0, rsp_valid}, 32'd0);
        check("R8 hold", {25'b0, rsp_hit, rsp_node, rsp_idx}, {25'b0, 7'b1_101_000});

        // R10 R6: clearing window 0 enables hands overlap to window 1
        wr(0, 0, 32'h0010_0000);
        probe("R10 R6 takeover", 40'h00_1800_0000, 1'b0);
        probe("R10 R7 lost window", 40'h00_1000_0000, 1'b0);
        probe("R2 read-only refuses write", 40'h00_1800_0000, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule